// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each of the two ALU operands of an instruction in the execute stage of a five-stage pipeline, where that operand's value should come from. It compares the two source register numbers of the executing instruction with the destination register numbers of the two older instructions still in flight: the one in the memory stage and the one in the write-back stage. For each operand it produces a 2-bit select that picks one of three values: the register file read value, the memory-stage ALU result, or the write-back-stage value.

The unit is purely combinational. A select is valid in the same cycle as the register numbers and write enables it depends on. Register 0 is hard-wired to zero, so it is never a forwarding target. When both older instructions write the same register, the younger one in the memory stage supplies the value. Hazards where the write-back and the register read fall in the same cycle are resolved by the register file's internal bypass, so this unit does not handle them. The operand multiplexers, the ALU and load-use stall detection are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: When memRegWrite is 1, memRdIdx is nonzero and memRdIdx equals exRsIdx, forwardA is 2'b10 (memory-stage ALU result).
- R2: When memRegWrite is 1, memRdIdx is nonzero and memRdIdx equals exRtIdx, forwardB is 2'b10.
- R3: When wbRegWrite is 1, wbRdIdx is nonzero and wbRdIdx equals exRsIdx, and the R1 condition does not hold, forwardA is 2'b01 (write-back value).
- R4: When wbRegWrite is 1, wbRdIdx is nonzero and wbRdIdx equals exRtIdx, and the R2 condition does not hold, forwardB is 2'b01.
- R5: When both older writers are enabled and target the same nonzero source register, that operand's select is 2'b10, so the younger memory-stage result wins.
- R6: A source index of 0 always gives select 2'b00, whatever the writers' destinations and enables are.
- R7: A writer whose write enable is 0 has no effect on either select, even when its destination matches a source.
- R8: When no enabled writer with a nonzero destination matches a source, that operand's select is 2'b00 (register file value), and the code 2'b11 never appears.
- R9: forwardA depends only on exRsIdx and forwardB only on exRtIdx, so the two operands may forward from different stages in the same cycle.
- R10: Both selects are combinational and follow their inputs in the same cycle, with no clock and no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exRsIdx | input | REG_ADDR_W (5) | First source register number of the executing instruction |
| exRtIdx | input | REG_ADDR_W (5) | Second source register number of the executing instruction |
| memRdIdx | input | REG_ADDR_W (5) | Destination register number of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes its destination |
| wbRdIdx | input | REG_ADDR_W (5) | Destination register number of the write-back-stage instruction |
| wbRegWrite | input | 1 | Write-back-stage instruction writes its destination |
| forwardA | output | 2 | Select for operand A: 00 register file, 01 write-back, 10 memory stage |
| forwardB | output | 2 | Select for operand B, same encoding as forwardA |

## Verification
Both selects are due in the same cycle as the stimulus, because no register lies between the ports. The bench changes the inputs just after a rising clock edge and reads the selects at the following falling edge, half a period later, so every check sees settled combinational outputs. It never compares against a value from an earlier cycle. Random register numbers are drawn from a narrow range so that matches, double matches and zero indices occur often, and directed cases add the priority, zero-register and disabled-writer corners.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Width of a register number; 32 architectural registers by default
  localparam int REG_ADDR_W = 5;
  // Number of ALU operands that need a select
  localparam int NUM_SRC = 2;

  // Operand source selection codes
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WBACK   = 2'b01,
    SEL_MEMSTG  = 2'b10
  } fwdSel_e;

  // Match strobes handed from the comparator datapath to the select control
  typedef struct packed {
    logic [NUM_SRC-1:0] memHit;
    logic [NUM_SRC-1:0] wbHit;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_match_dp.sv
module fwd_match_dp
  import fwd_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic [ADDR_W-1:0] exRsIdx,
  input  logic [ADDR_W-1:0] exRtIdx,
  input  logic [ADDR_W-1:0] memRdIdx,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRdIdx,
  input  logic              wbRegWrite,
  output fwdStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic [ADDR_W-1:0] srcIdx [NUM_SRC];
  logic              memWriterLive;
  logic              wbWriterLive;

  // A writer counts only if it writes and its target is not the zero register
  assign memWriterLive = memRegWrite && (memRdIdx != ZERO_REG);
  assign wbWriterLive  = wbRegWrite  && (wbRdIdx  != ZERO_REG);

  assign srcIdx[0] = exRsIdx;
  assign srcIdx[1] = exRtIdx;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
    assign strobes.memHit[s] = memWriterLive && (memRdIdx == srcIdx[s]);
    assign strobes.wbHit[s]  = wbWriterLive  && (wbRdIdx  == srcIdx[s]);
  end

endmodule

// File: rtl/fwd_sel_ctl.sv
module fwd_sel_ctl
  import fwd_pkg::*;
(
  input  fwdStrobes_t strobes,
  output fwdSel_e     srcSel [NUM_SRC]
);

  // Younger producer (memory stage) outranks the older one (write-back)
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pri
    always_comb begin
      if (strobes.memHit[s])
        srcSel[s] = SEL_MEMSTG;
      else if (strobes.wbHit[s])
        srcSel[s] = SEL_WBACK;
      else
        srcSel[s] = SEL_REGFILE;
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic [ADDR_W-1:0] exRsIdx,
  input  logic [ADDR_W-1:0] exRtIdx,
  input  logic [ADDR_W-1:0] memRdIdx,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbRdIdx,
  input  logic              wbRegWrite,
  output logic [1:0]        forwardA,
  output logic [1:0]        forwardB
);

  fwdStrobes_t strobes;
  fwdSel_e     srcSel [NUM_SRC];

  fwd_match_dp #(.ADDR_W(ADDR_W)) u_dp (
    .exRsIdx    (exRsIdx),
    .exRtIdx    (exRtIdx),
    .memRdIdx   (memRdIdx),
    .memRegWrite(memRegWrite),
    .wbRdIdx    (wbRdIdx),
    .wbRegWrite (wbRegWrite),
    .strobes    (strobes)
  );

  fwd_sel_ctl u_ctl (
    .strobes(strobes),
    .srcSel (srcSel)
  );

  assign forwardA = srcSel[0];
  assign forwardB = srcSel[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int ADDR_W = 5
) (
  input logic [ADDR_W-1:0] exRsIdx,
  input logic [ADDR_W-1:0] exRtIdx,
  input logic [ADDR_W-1:0] memRdIdx,
  input logic              memRegWrite,
  input logic [ADDR_W-1:0] wbRdIdx,
  input logic              wbRegWrite,
  input logic [1:0]        forwardA,
  input logic [1:0]        forwardB
);

  logic memLive, wbLive;
  assign memLive = memRegWrite && (memRdIdx != '0);
  assign wbLive  = wbRegWrite  && (wbRdIdx  != '0);

  // Combinational block: immediate checks evaluated whenever any port moves
  always_comb begin
    if (memLive && memRdIdx == exRsIdx)
      AST_MEM_FWD_A: assert (forwardA == 2'b10) else $error("forwardA not mem");          // R1
    if (memLive && memRdIdx == exRtIdx)
      AST_MEM_FWD_B: assert (forwardB == 2'b10) else $error("forwardB not mem");          // R2
    if (!(memLive && memRdIdx == exRsIdx) && wbLive && wbRdIdx == exRsIdx)
      AST_WB_FWD_A: assert (forwardA == 2'b01) else $error("forwardA not wb");            // R3
    if (!(memLive && memRdIdx == exRtIdx) && wbLive && wbRdIdx == exRtIdx)
      AST_WB_FWD_B: assert (forwardB == 2'b01) else $error("forwardB not wb");            // R4
    if (exRsIdx == '0)
      AST_ZERO_SRC_A: assert (forwardA == 2'b00) else $error("zero reg forwarded A");     // R6
    if (exRtIdx == '0)
      AST_ZERO_SRC_B: assert (forwardB == 2'b00) else $error("zero reg forwarded B");     // R6
    if (!memRegWrite && !wbRegWrite)
      AST_NO_WRITER: assert (forwardA == 2'b00 && forwardB == 2'b00) else $error("disabled writer used"); // R7
    AST_NO_CODE3: assert (forwardA != 2'b11 && forwardB != 2'b11) else $error("illegal select"); // R8
    if (exRsIdx == exRtIdx)
      AST_SAME_SRC: assert (forwardA == forwardB) else $error("independent selects differ"); // R9
  end

endmodule

bind fwd_unit fwd_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;

  localparam int AW = 5;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] exRsIdx, exRtIdx, memRdIdx, wbRdIdx;
  logic          memRegWrite, wbRegWrite;
  logic [1:0]    forwardA, forwardB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fwd_unit u_dut (
    .exRsIdx(exRsIdx), .exRtIdx(exRtIdx),
    .memRdIdx(memRdIdx), .memRegWrite(memRegWrite),
    .wbRdIdx(wbRdIdx), .wbRegWrite(wbRegWrite),
    .forwardA(forwardA), .forwardB(forwardB)
  );

  // Reference select from the requirement text
  function automatic logic [1:0] refSel(logic [AW-1:0] src, logic [AW-1:0] mRd, logic mWe,
                                        logic [AW-1:0] wRd, logic wWe);
    if (mWe && mRd != 0 && mRd == src) return 2'b10;
    if (wWe && wRd != 0 && wRd == src) return 2'b01;
    return 2'b00;
  endfunction

  // Requirement a random case falls under, for the message
  function automatic string reqTag(bit isA, logic [AW-1:0] src, logic [AW-1:0] mRd, logic mWe,
                                   logic [AW-1:0] wRd, logic wWe);
    if (src == 0) return "R6";
    if (mWe && mRd != 0 && mRd == src && wWe && wRd == src) return "R5";
    if (mWe && mRd != 0 && mRd == src) return isA ? "R1" : "R2";
    if (wWe && wRd != 0 && wRd == src) return isA ? "R3" : "R4";
    if ((!mWe && mRd == src) || (!wWe && wRd == src)) return "R7";
    return "R8";
  endfunction

  task automatic checkVal(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive just after a rising edge, check at the falling edge (R10: same cycle)
  task automatic applyCase(logic [AW-1:0] rs, logic [AW-1:0] rt, logic [AW-1:0] mRd, logic mWe,
                           logic [AW-1:0] wRd, logic wWe, string reqA, string reqB);
    @(posedge clk);
    #1;
    exRsIdx = rs; exRtIdx = rt; memRdIdx = mRd; memRegWrite = mWe;
    wbRdIdx = wRd; wbRegWrite = wWe;
    @(negedge clk);
    checkVal(reqA, "forwardA", forwardA, refSel(rs, mRd, mWe, wRd, wWe));
    checkVal(reqB, "forwardB", forwardB, refSel(rt, mRd, mWe, wRd, wWe));
  endtask

  initial begin
    int unused;
    exRsIdx = '0; exRtIdx = '0; memRdIdx = '0; wbRdIdx = '0;
    memRegWrite = 1'b0; wbRegWrite = 1'b0;
    unused = $urandom(32'd20240611);
    // Idle state: nothing in flight
    @(negedge clk);
    checkVal("R8", "idle forwardA", forwardA, 2'b00);
    checkVal("R8", "idle forwardB", forwardB, 2'b00);

    applyCase(5'd2, 5'd7, 5'd2, 1'b1, 5'd9, 1'b1, "R1", "R8");
    applyCase(5'd4, 5'd3, 5'd3, 1'b1, 5'd0, 1'b0, "R8", "R2");
    applyCase(5'd6, 5'd1, 5'd8, 1'b1, 5'd6, 1'b1, "R3", "R8");
    applyCase(5'd1, 5'd12, 5'd5, 1'b0, 5'd12, 1'b1, "R8", "R4");
    applyCase(5'd10, 5'd10, 5'd10, 1'b1, 5'd10, 1'b1, "R5", "R5");
    applyCase(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R6", "R6");
    applyCase(5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1, "R6", "R4");
    applyCase(5'd11, 5'd11, 5'd11, 1'b0, 5'd11, 1'b0, "R7", "R7");
    applyCase(5'd11, 5'd14, 5'd11, 1'b0, 5'd14, 1'b1, "R7", "R4");
    applyCase(5'd31, 5'd30, 5'd31, 1'b1, 5'd30, 1'b1, "R9", "R9");
    applyCase(5'd30, 5'd31, 5'd31, 1'b1, 5'd30, 1'b1, "R9", "R9");
    applyCase(5'd9, 5'd13, 5'd20, 1'b1, 5'd21, 1'b1, "R8", "R8");

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] rs, rt, mRd, wRd;
      logic mWe, wWe;
      rs  = AW'($urandom_range(0, 3));
      rt  = AW'($urandom_range(0, 3));
      mRd = AW'($urandom_range(0, 3));
      wRd = AW'($urandom_range(0, 3));
      mWe = 1'($urandom_range(0, 1));
      wWe = 1'($urandom_range(0, 1));
      applyCase(rs, rt, mRd, mWe, wRd, wWe,
                reqTag(1'b1, rs, mRd, mWe, wRd, wWe), reqTag(1'b0, rt, mRd, mWe, wRd, wWe));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < MAX_CYCLES; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule